// File: doc/BRIEF.md
# Preamble-Regenerating Transmit Elasticity Buffer

This block sits in the transmit path of a multi-port repeater, between the decoded receive stream and the per-port encoders. The incoming stream is NRZ, one bit per `rx_stb` pulse, framed by `rx_en`. As soon as a receiving source is active, the block starts to send an alternating preamble on the outgoing side, one bit per `tx_tick`. It does this without waiting for any data. Meanwhile it hunts the incoming stream for the end of the start-of-frame delimiter and drops every bit before it. The bits that follow go into a small bit-wide FIFO.

The buffered bits are held back until a full-length header has gone out: 56 alternating bits and then a locally generated 8-bit delimiter. After that the FIFO is drained onto the output. A collision, a buffer overflow or a buffer underflow replaces the outgoing data with the alternating jam sequence. Any transmission shorter than the minimum length is padded with jam before the output enable falls.

Top module: `pre_regen_ebuf`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `tx_en`, `tx_dat`, `ovf` and `udf` are all 0.
- R2: On the first `tx_tick` edge at which `rx_en` is high while idle, `tx_en` rises and the output begins. Output bits 0 to 55 alternate, starting with 1 (bit i is 1 when i is even).
- R3: Output bits 56 to 63 are the delimiter 1,0,1,0,1,0,1,1 in time order. They are produced locally, whatever the input contains.
- R4: Input bits received before two consecutive ones (the delimiter tail) are discarded. Bits after that are stored, up to 32 of them, and appear on the output in arrival order from output bit 64 onward, never earlier.
- R5: At any `tx_tick` edge with `col` high while transmitting, the next output bit is jam. Jam is a sequence that alternates and whose first bit is 1. Jam continues while `col` or `rx_en` is high. Buffered and later input bits of that frame are dropped.
- R6: A bit that arrives while 32 bits are stored raises `ovf` for exactly one cycle. The rest of that frame is dropped, and the output switches to jam at the next `tx_tick` as if a collision had occurred.
- R7: A transmission carries at least 96 bits. `tx_en` falls at the first `tx_tick` at which the buffer is empty, `rx_en` and `col` are low, and 96 bits have been sent. Short frames are padded with jam until then.
- R8: In the data phase, a `tx_tick` that finds the buffer empty while `rx_en` is still high raises `udf` for one cycle, and the output switches to jam.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_stb | input | 1 | Input bit strobe: `rx_dat` is sampled at this edge |
| rx_en | input | 1 | Receive activity / framing enable |
| rx_dat | input | 1 | Decoded NRZ receive data |
| col | input | 1 | Collision indication |
| tx_tick | input | 1 | Output bit-time enable |
| tx_en | output | 1 | Transmit enable, registered |
| tx_dat | output | 1 | Transmit NRZ data, registered (0 when idle) |
| ovf | output | 1 | One-cycle overflow pulse |
| udf | output | 1 | One-cycle underflow pulse |

## Verification
Several properties are checked on every cycle by the assertions:
- a collision tick forces the jam state;
- the first transmitted bit is 1;
- the FIFO is never read before the header has been sent, and never written while full;
- the enable only falls once the minimum length is met;
- both error pulses last exactly one cycle.

Other behaviour can only be shown by the bench's scenarios: the exact content of the header, the order of the data, the point where the input preamble stops and data begins, padding of a short frame, and the jam that follows an overflow or underflow caused by mismatched input and output rates. These scenarios are checked against a behavioural model on every clock.

// File: rtl/ebuf_pkg.sv
package ebuf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DATA = 2'd2,
    ST_JAM  = 2'd3
  } tx_state_t;
endpackage

// File: rtl/ebuf_fifo.sv
module ebuf_fifo #(
  parameter int DEPTH = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic wr,
  input  logic wdat,
  input  logic rd,
  output logic head,
  output logic full,
  output logic empty
);
  localparam int AW = $clog2(DEPTH);

  logic          mem [DEPTH];
  logic [AW:0]   wptr, rptr;
  logic [AW:0]   fill;

  assign fill  = wptr - rptr;
  assign full  = (fill == (AW+1)'(DEPTH));
  assign empty = (wptr == rptr);
  assign head  = mem[rptr[AW-1:0]];

  // storage: write-only port, no reset, so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (wr) mem[wptr[AW-1:0]] <= wdat;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr) wptr <= wptr + 1'b1;
      if (rd) rptr <= rptr + 1'b1;
    end
  end

  // R6: the writer must never push into a full buffer
  a_r6_no_write_full: assert property (@(posedge clk) disable iff (rst)
    wr |-> !full);
  // R4: reads only happen on stored data
  a_r4_no_read_empty: assert property (@(posedge clk) disable iff (rst)
    rd |-> !empty);
endmodule

// File: rtl/ebuf_rx_hunt.sv
module ebuf_rx_hunt (
  input  logic clk,
  input  logic rst,
  input  logic rx_stb,
  input  logic rx_en,
  input  logic rx_dat,
  input  logic jam_active,
  input  logic full,
  output logic wr,
  output logic wdat,
  output logic ovf,
  output logic err_hold
);
  logic locked;
  logic last_bit;
  logic take;
  logic spill;

  assign take  = rx_stb && rx_en && locked && !jam_active && !err_hold;
  assign spill = take && full;
  assign wr    = take && !full;
  assign wdat  = rx_dat;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked   <= 1'b0;
      last_bit <= 1'b0;
      err_hold <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      ovf <= spill;
      if (!rx_en) begin
        locked   <= 1'b0;
        last_bit <= 1'b0;
        err_hold <= 1'b0;
      end else begin
        if (spill) err_hold <= 1'b1;
        if (rx_stb && !locked) begin
          if (last_bit && rx_dat) locked <= 1'b1;
          last_bit <= rx_dat;
        end
      end
    end
  end

  // R6: overflow is reported once per frame as a single-cycle pulse
  a_r6_ovf_pulse: assert property (@(posedge clk) disable iff (rst)
    ovf |=> !ovf);
endmodule

// File: rtl/ebuf_tx_seq.sv
module ebuf_tx_seq
  import ebuf_pkg::*;
#(
  parameter int PRE_BITS = 56,
  parameter int MIN_BITS = 96
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_tick,
  input  logic rx_en,
  input  logic col,
  input  logic err_hold,
  input  logic empty,
  input  logic head,
  output logic rd,
  output logic jam_active,
  output logic tx_en,
  output logic tx_dat,
  output logic udf
);
  localparam int CW = $clog2(MIN_BITS + 1);
  localparam logic [CW-1:0] HDR_LAST = CW'(PRE_BITS + 7);
  localparam logic [CW-1:0] MIN_C    = CW'(MIN_BITS);

  tx_state_t     st, st_n;
  logic [CW-1:0] bcnt;
  logic          emit, bit_n, stop, udf_n;
  logic          jam_req, jam_bit, hdr_bit, min_done;

  assign jam_active = (st == ST_JAM);
  assign min_done   = (bcnt == MIN_C);
  assign jam_req    = col || err_hold;
  assign jam_bit    = (st == ST_JAM) ? !tx_dat : 1'b1;
  assign hdr_bit    = (bcnt == HDR_LAST) ? 1'b1 : !bcnt[0];

  always_comb begin
    st_n  = st;
    emit  = 1'b0;
    bit_n = 1'b0;
    stop  = 1'b0;
    udf_n = 1'b0;
    rd    = 1'b0;
    if (tx_tick) begin
      unique case (st)
        ST_IDLE: begin
          if (rx_en) begin
            emit  = 1'b1;
            bit_n = 1'b1;
            st_n  = ST_HDR;
          end
        end
        ST_HDR: begin
          emit = 1'b1;
          if (jam_req) begin
            bit_n = jam_bit;
            st_n  = ST_JAM;
          end else begin
            bit_n = hdr_bit;
            if (bcnt == HDR_LAST) st_n = ST_DATA;
          end
        end
        ST_DATA: begin
          if (jam_req) begin
            emit  = 1'b1;
            bit_n = jam_bit;
            st_n  = ST_JAM;
          end else if (!empty) begin
            emit  = 1'b1;
            bit_n = head;
            rd    = 1'b1;
          end else if (rx_en) begin
            emit  = 1'b1;
            bit_n = jam_bit;
            udf_n = 1'b1;
            st_n  = ST_JAM;
          end else if (min_done) begin
            stop = 1'b1;
            st_n = ST_IDLE;
          end else begin
            emit  = 1'b1;
            bit_n = jam_bit;
            st_n  = ST_JAM;
          end
        end
        ST_JAM: begin
          if (!jam_req && !rx_en && min_done) begin
            stop = 1'b1;
            st_n = ST_IDLE;
          end else begin
            emit  = 1'b1;
            bit_n = jam_bit;
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      bcnt   <= '0;
      tx_en  <= 1'b0;
      tx_dat <= 1'b0;
      udf    <= 1'b0;
    end else begin
      st  <= st_n;
      udf <= udf_n;
      if (emit) begin
        tx_en  <= 1'b1;
        tx_dat <= bit_n;
        if (st == ST_IDLE)  bcnt <= CW'(1);
        else if (!min_done) bcnt <= bcnt + 1'b1;
      end else if (stop) begin
        tx_en  <= 1'b0;
        tx_dat <= 1'b0;
      end
    end
  end

  // R2: every transmission opens with a 1
  a_r2_first_bit_one: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> tx_dat);
  // R4: the buffer is not drained before the full header has gone out
  a_r4_read_after_hdr: assert property (@(posedge clk) disable iff (rst)
    rd |-> (bcnt > HDR_LAST));
  // R5: a collision seen at a bit time forces jam
  a_r5_col_jam: assert property (@(posedge clk) disable iff (rst)
    (tx_tick && col && st != ST_IDLE) |=> jam_active);
  // R7: enable never falls short of the minimum length
  a_r7_min_bits: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_en) |-> min_done);
  // R8: underflow is a single pulse that comes with jam
  a_r8_udf_pulse: assert property (@(posedge clk) disable iff (rst)
    udf |-> (jam_active && tx_en));
  a_r8_udf_single: assert property (@(posedge clk) disable iff (rst)
    udf |=> !udf);
endmodule

// File: rtl/pre_regen_ebuf.sv
module pre_regen_ebuf #(
  parameter int DEPTH    = 32,
  parameter int PRE_BITS = 56,
  parameter int MIN_BITS = 96
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_stb,
  input  logic rx_en,
  input  logic rx_dat,
  input  logic col,
  input  logic tx_tick,
  output logic tx_en,
  output logic tx_dat,
  output logic ovf,
  output logic udf
);
  logic wr, wdat, rd, head, full, empty;
  logic jam_active, err_hold;

  ebuf_rx_hunt u_hunt (
    .clk        (clk),
    .rst        (rst),
    .rx_stb     (rx_stb),
    .rx_en      (rx_en),
    .rx_dat     (rx_dat),
    .jam_active (jam_active),
    .full       (full),
    .wr         (wr),
    .wdat       (wdat),
    .ovf        (ovf),
    .err_hold   (err_hold)
  );

  ebuf_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .flush (jam_active),
    .wr    (wr),
    .wdat  (wdat),
    .rd    (rd),
    .head  (head),
    .full  (full),
    .empty (empty)
  );

  ebuf_tx_seq #(.PRE_BITS(PRE_BITS), .MIN_BITS(MIN_BITS)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .tx_tick    (tx_tick),
    .rx_en      (rx_en),
    .col        (col),
    .err_hold   (err_hold),
    .empty      (empty),
    .head       (head),
    .rd         (rd),
    .jam_active (jam_active),
    .tx_en      (tx_en),
    .tx_dat     (tx_dat),
    .udf        (udf)
  );
endmodule

// File: tb/pre_regen_ebuf_tb.sv
module pre_regen_ebuf_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_stb = 1'b0, rx_en = 1'b0, rx_dat = 1'b0, col = 1'b0, tx_tick = 1'b0;
  logic tx_en, tx_dat, ovf, udf;

  int checks = 0;
  int errs = 0;
  int cyc = 0;
  int fails_shown = 0;

  always #4 clk = ~clk;

  pre_regen_ebuf u_dut (
    .clk(clk), .rst(rst), .rx_stb(rx_stb), .rx_en(rx_en), .rx_dat(rx_dat),
    .col(col), .tx_tick(tx_tick), .tx_en(tx_en), .tx_dat(tx_dat),
    .ovf(ovf), .udf(udf)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      if (fails_shown < 20)
        $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      fails_shown++;
    end
  endtask

  function automatic bit dbit(input int k);
    return ((k * 13 + k / 3) % 5) < 2;
  endfunction

  // ---------------- behavioural reference model ----------------
  int m_st = 0;   // 0 idle, 1 header, 2 data, 3 jam
  int m_cnt = 0;
  bit m_txen = 0, m_txdat = 0, m_ovf = 0, m_udf = 0;
  bit m_lock = 0, m_prev = 0, m_err = 0;
  bit q[$];

  task automatic model_step();
    int  old_st, old_size;
    bit  old_err, old_dat, jr, jb, em, eb, stp, n_ovf, n_udf;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_txen = 0; m_txdat = 0; m_ovf = 0; m_udf = 0;
      m_lock = 0; m_prev = 0; m_err = 0; q.delete();
      return;
    end
    old_st = m_st; old_err = m_err; old_dat = m_txdat;
    if (old_st == 3) q.delete();
    old_size = q.size();
    n_ovf = 0; n_udf = 0; em = 0; eb = 0; stp = 0;
    if (tx_tick) begin
      jr = col || old_err;
      jb = (old_st == 3) ? !old_dat : 1'b1;
      case (old_st)
        0: if (rx_en) begin em = 1; eb = 1; m_st = 1; m_cnt = 0; end
        1: begin
          em = 1;
          if (jr) begin eb = jb; m_st = 3; end
          else begin
            eb = (m_cnt == 63) ? 1'b1 : ((m_cnt % 2) == 0);
            if (m_cnt == 63) m_st = 2;
          end
        end
        2: begin
          if (jr) begin em = 1; eb = jb; m_st = 3; end
          else if (old_size > 0) begin em = 1; eb = q.pop_front(); end
          else if (rx_en) begin em = 1; eb = jb; n_udf = 1; m_st = 3; end
          else if (m_cnt >= 96) stp = 1;
          else begin em = 1; eb = jb; m_st = 3; end
        end
        default: begin
          if (!jr && !rx_en && m_cnt >= 96) stp = 1;
          else begin em = 1; eb = jb; end
        end
      endcase
      if (em) begin
        m_txen = 1; m_txdat = eb;
        m_cnt = (m_cnt < 96) ? m_cnt + 1 : 96;
      end else if (stp) begin
        m_txen = 0; m_txdat = 0; m_st = 0;
      end
    end
    if (!rx_en) begin
      m_lock = 0; m_prev = 0; m_err = 0;
    end else if (rx_stb) begin
      if (!m_lock) begin
        if (m_prev && rx_dat) m_lock = 1;
        m_prev = rx_dat;
      end else if (old_st != 3 && !old_err) begin
        if (old_size == 32) begin n_ovf = 1; m_err = 1; end
        else q.push_back(rx_dat);
      end
    end
    m_ovf = n_ovf; m_udf = n_udf;
  endtask

  bit outq[$];
  int n_ovf = 0, n_udf = 0;

  always @(posedge clk) begin
    model_step();
    #2;
    chk(tx_en === m_txen, "R2/R5/R7", "cycle tx_en", int'(tx_en), int'(m_txen));
    chk(tx_dat === m_txdat, "R3/R4/R5", "cycle tx_dat", int'(tx_dat), int'(m_txdat));
    chk(ovf === m_ovf, "R6", "cycle ovf", int'(ovf), int'(m_ovf));
    chk(udf === m_udf, "R8", "cycle udf", int'(udf), int'(m_udf));
    if (!rst) begin
      if (tx_tick && tx_en) outq.push_back(tx_dat);
      if (ovf) n_ovf++;
      if (udf) n_udf++;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic run_frame(input int hdr, input int nd, input int rxd,
                           input int txd, input int cs, input int cl);
    bit inq[$];
    int c;
    int idx;
    bit seen;
    for (int i = 0; i < hdr; i++) inq.push_back((i % 2) == 0);
    inq.push_back(1'b1);
    inq.push_back(1'b1);
    for (int k = 0; k < nd; k++) inq.push_back(dbit(k));
    outq.delete(); n_ovf = 0; n_udf = 0;
    c = 0; seen = 0;
    forever begin
      @(negedge clk);
      idx = c / rxd;
      if (idx < inq.size()) begin
        rx_en = 1'b1; rx_dat = inq[idx]; rx_stb = ((c % rxd) == 0);
      end else begin
        rx_en = 1'b0; rx_dat = 1'b0; rx_stb = 1'b0;
      end
      tx_tick = ((c % txd) == 0);
      col = (cs >= 0 && c >= cs && c < cs + cl);
      if (tx_en) seen = 1;
      if ((idx >= inq.size() && seen && !tx_en && !col) || c > 4000) break;
      c++;
    end
    repeat (4) begin
      @(negedge clk);
      rx_en = 1'b0; rx_stb = 1'b0; rx_dat = 1'b0; col = 1'b0; tx_tick = 1'b1;
    end
    @(negedge clk);
    tx_tick = 1'b0;
  endtask

  function automatic bit alt_from(input int s);
    for (int i = s + 1; i < outq.size(); i++)
      if (outq[i] == outq[i-1]) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    chk(tx_en === 1'b0 && tx_dat === 1'b0, "R1", "tx idle in reset", int'(tx_en), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_en === 1'b0 && ovf === 1'b0 && udf === 1'b0, "R1", "idle after reset",
        int'(tx_en) + int'(ovf) + int'(udf), 0);

    // normal frame, matched rates
    run_frame(40, 100, 1, 1, -1, 0);
    chk(outq.size() == 164, "R4", "normal length", outq.size(), 164);
    ok = 1;
    for (int i = 0; i < 56; i++) if (outq[i] != ((i % 2) == 0)) ok = 0;
    chk(ok, "R2", "preamble alternates from 1", int'(ok), 1);
    ok = (outq[56] == 1 && outq[57] == 0 && outq[58] == 1 && outq[59] == 0 &&
          outq[60] == 1 && outq[61] == 0 && outq[62] == 1 && outq[63] == 1);
    chk(ok, "R3", "delimiter regenerated", int'(ok), 1);
    ok = 1;
    for (int k = 0; k < 100; k++) if (outq[64+k] != dbit(k)) ok = 0;
    chk(ok, "R4", "data in order after header", int'(ok), 1);
    chk(n_ovf == 0 && n_udf == 0, "R6", "no error pulses", n_ovf + n_udf, 0);

    // longer input preamble: only post-delimiter bits forwarded
    run_frame(50, 60, 1, 1, -1, 0);
    ok = (outq.size() == 124);
    for (int k = 0; k < 60 && ok; k++) if (outq[64+k] != dbit(k)) ok = 0;
    chk(ok, "R4", "input preamble discarded", outq.size(), 124);

    // short frame padded to minimum
    run_frame(40, 10, 1, 1, -1, 0);
    chk(outq.size() == 96, "R7", "short frame length", outq.size(), 96);
    ok = 1;
    for (int k = 0; k < 10; k++) if (outq[64+k] != dbit(k)) ok = 0;
    chk(ok, "R7", "short frame data kept", int'(ok), 1);
    chk(outq[74] == 1 && alt_from(74), "R7", "pad is jam from 1", int'(outq[74]), 1);

    // collision mid-frame
    run_frame(40, 100, 1, 1, 80, 10);
    chk(outq.size() >= 96 && outq.size() < 164, "R5", "collision frame length",
        outq.size(), 142);
    chk(alt_from(outq.size() - 50), "R5", "jam tail alternates", 0, 1);

    // overflow: output at half rate
    run_frame(40, 100, 1, 2, -1, 0);
    chk(n_ovf == 1, "R6", "one overflow pulse", n_ovf, 1);
    chk(outq[0] == 1 && alt_from(0), "R6", "output is jam, no delimiter", int'(outq[0]), 1);
    chk(outq.size() >= 96, "R7", "overflow frame minimum", outq.size(), 96);

    // underflow: input at half rate
    run_frame(40, 100, 2, 1, -1, 0);
    chk(n_udf == 1, "R8", "one underflow pulse", n_udf, 1);
    chk(outq[64] == 1 && outq[65] == 0 && alt_from(64), "R8", "jam after underflow",
        int'(outq[64]), 1);

    // back-to-back normal frame after errors
    run_frame(44, 40, 1, 1, -1, 0);
    chk(outq.size() == 104 && n_ovf == 0 && n_udf == 0, "R2", "recovery frame",
        outq.size(), 104);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule